// File: doc/BRIEF.md
# Maskable Interrupt Event Aggregator

This block gathers interrupt events from several peripheral sources into one event register, qualifies them with a per-source enable mask and drives a single interrupt line towards the CPU. Two kinds of source exist side by side. A level-following source, such as a flash controller's completion flag, is mirrored into its event bit and disappears when the peripheral itself is cleared. A sticky source is latched on a one-cycle pulse and held until software clears it. One sticky bit is reserved for a change in memory-module presence. The block also tracks whether the module is present, and it can raise a security trap flag on each presence change.

Software reaches the block through a plain register port with four word addresses: events, mask, mode and status. The mask is never written directly. Each source owns a clear code bit and a set code bit in the written word, so several drivers can change their own enables without a read-modify-write. Writes take effect at the next rising clock edge. Reads are combinational from the address. The port has no valid/ready handshake, because no data stream passes through the block; every pin is a plain control or status signal.

Top module: `irq_event_agg`

## Requirements
- R1: After reset, the event, mask, trap-enable and trap bits are zero, the status bit reads 0 (inserted) and `cpu_irq` is low.
- R2: A level-following event bit (bit 0 by default) takes the value of its source input one clock later, whatever its mask bit is. Writes to the event register (address 0) do not change it.
- R3: A sticky event bit is set by a source pulse that lasts a single cycle, and it stays set until it is cleared.
- R4: Writing the event register (address 0) with bit i at 1 clears sticky event bit i. Bits written as 0 leave their events unchanged.
- R5: If a sticky event is set in the same cycle as a write that clears it, the bit ends up set.
- R6: `cpu_irq` is high exactly when some event bit and the mask bit of the same index are both 1. It is low for a set event whose mask bit is 0.
- R7: A write to the mask register (address 1) clears mask bit i when data bit 2i is 1 and sets it when data bit 2i+1 is 1. If both bits are 1, or neither is, the mask bit is unchanged. A read of address 1 returns the mask in bits NUM_SRC-1:0.
- R8: Any change of `mod_removed` sets sticky event bit PRES_IDX (bit 1 by default). Status bit 0 at address 3 reads 1 for removed and 0 for inserted, one clock after the input. Writes to address 3 have no effect.
- R9: Mode register bit 0 at address 2 is a read/write trap enable. When the enable is 1, a presence change sets trap bit 1 of the same register. Writing bit 1 as 0 clears the trap bit, and writing it as 1 leaves it as it is. A presence change in the same cycle as a clearing write leaves the trap bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_in | input | NUM_SRC | Source lines: the level for a level-following bit, a pulse for a sticky bit |
| mod_removed | input | 1 | Module presence level, 1 = removed |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 events, 1 mask, 2 mode, 3 status |
| reg_wdata | input | 2*NUM_SRC | Write data |
| reg_rdata | output | 2*NUM_SRC | Read data for `reg_addr` |
| cpu_irq | output | 1 | Interrupt line to the CPU |

## Verification
Software clears and hardware sets can land on the same clock edge. A write-one-to-clear of the presence event can coincide with a presence change, and a trap-clearing mode write can coincide with that same change. The bench forces both collisions in directed steps and checks that the event bit and the trap bit read back set afterwards. It also drives random streams of pulses, presence toggles and writes, so that these collisions occur again without being planned. A bench reference model judges every cycle: it applies the set-wins rule and compares the read data and `cpu_irq` after each edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    SEL_EVT  = 2'd0,
    SEL_MASK = 2'd1,
    SEL_MODE = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  localparam int MODE_EN_BIT   = 0;
  localparam int MODE_TRAP_BIT = 1;
endpackage

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MAP = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_in,
  input  logic [NUM_SRC-1:0] clr_in,
  output logic [NUM_SRC-1:0] ev_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (LEVEL_MAP[i]) begin : g_level
      always_ff @(posedge clk) begin
        if (rst) ev_q[i] <= 1'b0;
        else     ev_q[i] <= set_in[i];
      end
    end else begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst)            ev_q[i] <= 1'b0;
        else if (set_in[i]) ev_q[i] <= 1'b1;
        else if (clr_in[i]) ev_q[i] <= 1'b0;
      end

      // R3 R5
      sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_in[i] |=> ev_q[i]);

      // R3
      sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_q[i] && !clr_in[i]) |=> ev_q[i]);
    end
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_code,
  input  logic [NUM_SRC-1:0] clr_code,
  output logic [NUM_SRC-1:0] mask_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) mask_q[i] <= 1'b0;
      else if (set_code[i] && !clr_code[i]) mask_q[i] <= 1'b1;
      else if (clr_code[i] && !set_code[i]) mask_q[i] <= 1'b0;
    end

    // R7
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
      (set_code[i] && !clr_code[i]) |=> mask_q[i]);

    // R7
    mask_both_chk: assert property (@(posedge clk) disable iff (rst)
      (set_code[i] == clr_code[i]) |=> $stable(mask_q[i]));
  end
endmodule

// File: rtl/irq_pres_trap.sv
module irq_pres_trap (
  input  logic clk,
  input  logic rst,
  input  logic mod_removed,
  input  logic mode_wr,
  input  logic en_wval,
  input  logic trap_wval,
  output logic change,
  output logic removed_q,
  output logic trap_en_q,
  output logic trap_q
);
  assign change = (mod_removed != removed_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      removed_q <= 1'b0;
      trap_en_q <= 1'b0;
      trap_q    <= 1'b0;
    end else begin
      removed_q <= mod_removed;
      if (mode_wr) trap_en_q <= en_wval;
      if (change && trap_en_q)     trap_q <= 1'b1;
      else if (mode_wr && !trap_wval) trap_q <= 1'b0;
    end
  end

  // R8
  pres_status_chk: assert property (@(posedge clk) disable iff (rst)
    change |=> (removed_q != $past(removed_q)));

  // R9
  trap_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (change && trap_en_q) |=> trap_q);

  // R9
  trap_stay_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!trap_q && !change) |=> !trap_q);
endmodule

// File: rtl/irq_event_agg.sv
module irq_event_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MAP = 8'b0000_0001,
  parameter int PRES_IDX = 1,
  localparam int DW = 2 * NUM_SRC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               mod_removed,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic               cpu_irq
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_addr);

  logic               wr_evt, wr_mask, wr_mode;
  logic [NUM_SRC-1:0] ev_set, ev_clr, ev_q;
  logic [NUM_SRC-1:0] m_set, m_clr, mask_q;
  logic               pres_chg, removed_q, trap_en_q, trap_q;

  assign wr_evt  = reg_wr && (sel == SEL_EVT);
  assign wr_mask = reg_wr && (sel == SEL_MASK);
  assign wr_mode = reg_wr && (sel == SEL_MODE);

  always_comb begin
    ev_set = src_in;
    ev_set[PRES_IDX] = src_in[PRES_IDX] | pres_chg;
    ev_clr = wr_evt ? reg_wdata[NUM_SRC-1:0] : '0;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_code
    assign m_clr[i] = wr_mask && reg_wdata[2*i];
    assign m_set[i] = wr_mask && reg_wdata[2*i+1];
  end

  irq_evt_bank #(.NUM_SRC(NUM_SRC), .LEVEL_MAP(LEVEL_MAP)) evt_i (
    .clk(clk), .rst(rst), .set_in(ev_set), .clr_in(ev_clr), .ev_q(ev_q));

  irq_mask_bank #(.NUM_SRC(NUM_SRC)) mask_i (
    .clk(clk), .rst(rst), .set_code(m_set), .clr_code(m_clr), .mask_q(mask_q));

  irq_pres_trap pres_i (
    .clk(clk), .rst(rst), .mod_removed(mod_removed), .mode_wr(wr_mode),
    .en_wval(reg_wdata[MODE_EN_BIT]), .trap_wval(reg_wdata[MODE_TRAP_BIT]),
    .change(pres_chg), .removed_q(removed_q), .trap_en_q(trap_en_q),
    .trap_q(trap_q));

  assign cpu_irq = |(ev_q & mask_q);

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_EVT:  reg_rdata[NUM_SRC-1:0] = ev_q;
      SEL_MASK: reg_rdata[NUM_SRC-1:0] = mask_q;
      SEL_MODE: begin
        reg_rdata[MODE_EN_BIT]   = trap_en_q;
        reg_rdata[MODE_TRAP_BIT] = trap_q;
      end
      SEL_STAT: reg_rdata[0] = removed_q;
    endcase
  end

  // R8
  pres_event_chk: assert property (@(posedge clk) disable iff (rst)
    pres_chg |=> ev_q[PRES_IDX]);

  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> !cpu_irq);
endmodule

// File: tb/irq_event_agg_tb_top.sv
module irq_event_agg_tb_top;
  localparam int N  = 8;
  localparam int DW = 2 * N;
  localparam int PI = 1;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  src_in;
  logic          mod_removed;
  logic          reg_wr;
  logic [1:0]    reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic          cpu_irq;

  int n_cmp = 0;
  int n_bad = 0;

  logic [N-1:0] m_ev, m_mask;
  logic m_en, m_trap, m_st;

  always #10 clk = ~clk;

  irq_event_agg dut_i (
    .clk(clk), .rst(rst), .src_in(src_in), .mod_removed(mod_removed),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_irq(cpu_irq));

  function automatic logic [DW-1:0] exp_read(input logic [1:0] a);
    logic [DW-1:0] r = '0;
    case (a)
      2'd0: r[N-1:0] = m_ev;
      2'd1: r[N-1:0] = m_mask;
      2'd2: r[1:0] = {m_trap, m_en};
      default: r[0] = m_st;
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [1:0] a);
    case (a)
      2'd0: return "R2/R3/R4/R5/R8";
      2'd1: return "R7";
      2'd2: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic [N-1:0] s, input logic mr, input logic w,
                            input logic [1:0] a, input logic [DW-1:0] d);
    logic chg = (mr != m_st);
    logic [N-1:0] setv = s;
    logic [N-1:0] clrv = (w && a == 2'd0) ? d[N-1:0] : '0;
    setv[PI] = setv[PI] | chg;
    m_ev[0] = s[0];
    for (int i = 1; i < N; i++) m_ev[i] = setv[i] | (m_ev[i] & ~clrv[i]);
    if (w && a == 2'd1)
      for (int i = 0; i < N; i++) begin
        if (d[2*i+1] && !d[2*i]) m_mask[i] = 1'b1;
        else if (d[2*i] && !d[2*i+1]) m_mask[i] = 1'b0;
      end
    m_trap = (chg && m_en) | (m_trap & ~(w && a == 2'd2 && !d[1]));
    if (w && a == 2'd2) m_en = d[0];
    m_st = mr;
  endtask

  task automatic step(input logic [N-1:0] s, input logic mr, input logic w,
                      input logic [1:0] a, input logic [DW-1:0] d);
    src_in = s; mod_removed = mr; reg_wr = w; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model_step(s, mr, w, a, d);
    @(negedge clk);
    check(req_of(a), reg_rdata, exp_read(a));
    check("R6 irq", {{(DW-1){1'b0}}, cpu_irq}, {{(DW-1){1'b0}}, |(m_ev & m_mask)});
  endtask

  task automatic rd(input logic [1:0] a);
    step('0, mod_removed, 1'b0, a, '0);
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; src_in = '0; mod_removed = 1'b0; reg_wr = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    m_ev = '0; m_mask = '0; m_en = 1'b0; m_trap = 1'b0; m_st = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state of every register and the line
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1;
      check("R1 reset", reg_rdata, '0);
    end
    check("R1 irq", {{(DW-1){1'b0}}, cpu_irq}, '0);

    // R2 level source follows input, mask off, irq low (R6)
    step(8'h01, 0, 0, 2'd0, '0);
    step(8'h01, 0, 1, 2'd0, 16'h0001);  // R2 write does not clear level bit
    step(8'h00, 0, 0, 2'd0, '0);
    // R7 enable bit 0 and bit 3, then level source raises irq
    step('0, 0, 1, 2'd1, 16'b0000_0000_1000_0010);
    step(8'h01, 0, 0, 2'd1, '0);
    step(8'h00, 0, 0, 2'd0, '0);        // R6 line drops with source
    // R3 single-cycle pulse on bit 3 stays
    step(8'h08, 0, 0, 2'd0, '0);
    rd(2'd0); rd(2'd0);
    // R4 write 0 no effect, write 1 clears
    step('0, 0, 1, 2'd0, 16'h0000);
    step('0, 0, 1, 2'd0, 16'h0008);
    // R7 both codes leave mask unchanged
    step('0, 0, 1, 2'd1, 16'b0000_0000_1100_0000);
    step('0, 0, 1, 2'd1, 16'b0000_0000_0100_0000);  // clear bit 3
    // R8 presence removal, status and event
    step('0, 1, 0, 2'd3, '0);
    rd(2'd0);
    step('0, 1, 1, 2'd3, 16'hffff);     // R8 status write ignored
    // R5 presence change collides with W1C of the same bit
    step('0, 0, 1, 2'd0, 16'h0002);
    rd(2'd3);
    // R9 enable trap, then change with a clearing write in same cycle
    step('0, 0, 1, 2'd2, 16'h0001);
    step('0, 1, 1, 2'd2, 16'h0001);
    step('0, 1, 1, 2'd2, 16'h0003);     // R9 write 1 keeps trap
    step('0, 1, 1, 2'd2, 16'h0001);     // R9 write 0 clears trap
    step('0, 1, 1, 2'd2, 16'h0000);     // R9 disable
    step('0, 0, 0, 2'd2, '0);           // R9 no trap when disabled

    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] s = '0;
      logic mr = mod_removed;
      logic w;
      logic [1:0] a;
      logic [DW-1:0] d;
      for (int i = 0; i < N; i++) s[i] = ($urandom % 10) == 0;
      if (($urandom % 12) == 0) mr = ~mr;
      w = ($urandom % 3) == 0;
      a = 2'($urandom % 4);
      d = DW'($urandom);
      step(s, mr, w, a, d);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule